// File: doc/BRIEF.md
# Late-Write Pipelined Static Memory

This block is a single-clock synchronous memory that takes its write data one cycle after the address and controls. A rising clock edge captures the address, the select, the global write enable and the per-lane write enables. When that cycle is a write, the data word is taken on the following edge. Completed writes are not placed in the storage array at once. They wait in a holding stage and reach the array when a later write comes along. Reads look up the storage array and both pending write stages, and they take each 9-bit lane from the newest source that holds it. Read data goes through two registers, so it appears on the output after the second rising edge from the one that captured the read.

The 36-bit word is made of four 9-bit lanes. Lane 0 is bits 8:0, lane 1 is bits 17:9, lane 2 is bits 26:18 and lane 3 is bits 35:27. The output is modelled with a drive flag. When the flag is low, the output is in high impedance and the data bus reads zero. Three things turn the drive off: an asynchronous output enable, a synchronous sleep input, and any cycle that is not a read. A host uses the block in place of an external memory chip that has a common data bus, because this protocol needs no idle turnaround cycle between a read and a write.

Top module: `lateWriteSram`

## Requirements
- R1: A read captured at edge T drives its word after edge T+1, and rdOn is high only when the cycle captured two edges earlier was a read (select low, write enable high, sleep low).
- R2: For a write captured at edge T, the data word is taken from wrData at edge T+1, and wrData is ignored on every other edge.
- R3: A read of an address whose write data arrives on the same edge returns that new data. The write is not yet in the array, so the data comes from the pending stage that is still waiting for its data.
- R4: A read of an address held in the completed-write buffer returns the buffered data even though the array has not been updated yet.
- R5: After a write to only some lanes, a read returns the written lanes from the buffer and all other lanes from the word already stored.
- R6: When both pending stages hold the same address, the newer write wins in every lane it enables, and the older write supplies the other lanes it enabled.
- R7: byteWrN bit i (active low) enables lane i, which covers bits 9i+8 down to 9i. A lane is written only when selN and wrN are both low, and with wrN high the cycle is a read whatever byteWrN holds.
- R8: A cycle with selN high does no access and writes nothing. The drive is off after the second edge from the one that captured it.
- R9: While sleep is captured high, the drive is off and no access takes place. Stored contents, including pending writes, survive sleep.
- R10: oeN high forces rdOn low and rdData to zero at once, with no clock edge needed.
- R11: After reset, rdOn is low and rdData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of control state |
| addr | input | ADDR_W | Word address, captured each edge |
| selN | input | 1 | Synchronous select, active low |
| wrN | input | 1 | Global write enable, active low |
| byteWrN | input | LANES | Per-lane write enables, active low |
| wrData | input | LANES*LANE_W | Write data, one cycle after its address |
| sleep | input | 1 | Synchronous sleep request |
| oeN | input | 1 | Asynchronous output enable, active low |
| rdData | output | LANES*LANE_W | Read word, zero while the drive is off |
| rdOn | output | 1 | Output drive active (low means high impedance) |

## Verification
The reads are arranged so that each possible source of a lane is tested on its own. A read on the same edge as the write data exercises the stage still waiting for its data. A read one idle cycle later exercises the completed buffer. A read after two further writes exercises the committed array. A partial write followed by a read tells whether the merge works per lane or per word. Two writes to one address followed by an immediate read tell whether the newer stage has priority. Back-to-back reads of different addresses test the latency and make sure successive words do not mix. Writes attempted during deselect, during sleep, and with wrN high but all lane enables low are each followed by a read-back, which shows whether anything was stored.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

  typedef struct packed {
    logic capData;   // pending-address stage takes its data word
    logic commitEn;  // completed buffer goes into the array
    logic loadMid;   // lookup result captured
    logic loadOut;   // output register loaded
  } ctrlStrobe_t;

endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selN,
  input  logic              wrN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              sleep,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [LANES-1:0]  commitBe,
  output logic [LANES-1:0]  useA,
  output logic [LANES-1:0]  useB,
  output logic              driveOn,
  output logic              sleepOn
);

  logic              isWrite;
  logic              isRead;
  logic              aValid;
  logic [ADDR_W-1:0] aAddr;
  logic [LANES-1:0]  aBe;
  logic              bValid;
  logic [ADDR_W-1:0] bAddr;
  logic [LANES-1:0]  bBe;
  logic              rdPend;
  logic              driveReg;
  logic              sleepReg;
  logic              hitA;
  logic              hitB;

  assign isWrite = !selN && !wrN && !sleep;
  assign isRead  = !selN &&  wrN && !sleep;

  // Completed write leaves the buffer when a new write arrives or when it is displaced
  assign strobe.commitEn = bValid && (isWrite || aValid);
  assign strobe.capData  = aValid;
  assign strobe.loadMid  = isRead;
  assign strobe.loadOut  = rdPend;

  assign commitAddr = bAddr;
  assign commitBe   = bBe;

  assign hitA = aValid && (aAddr == addr);
  assign hitB = bValid && (bAddr == addr);

  for (genvar l = 0; l < LANES; l++) begin : g_laneSel
    assign useA[l] = hitA && aBe[l];
    assign useB[l] = hitB && bBe[l] && !(hitA && aBe[l]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aValid   <= 1'b0;
      bValid   <= 1'b0;
      rdPend   <= 1'b0;
      driveReg <= 1'b0;
      sleepReg <= 1'b0;
    end else begin
      aValid <= isWrite;
      if (aValid) begin
        bValid <= 1'b1;
      end else if (strobe.commitEn) begin
        bValid <= 1'b0;
      end
      rdPend   <= isRead;
      driveReg <= rdPend;
      sleepReg <= sleep;
    end
  end

  always_ff @(posedge clk) begin
    if (isWrite) begin
      aAddr <= addr;
      aBe   <= ~byteWrN;
    end
    if (aValid) begin
      bAddr <= aAddr;
      bBe   <= aBe;
    end
  end

  assign driveOn = driveReg;
  assign sleepOn = sleepReg;

endmodule

// File: rtl/lwsram_data.sv
module lwsram_data
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  ctrlStrobe_t             strobe,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic [ADDR_W-1:0]       commitAddr,
  input  logic [LANES-1:0]        commitBe,
  input  logic [LANES-1:0]        useA,
  input  logic [LANES-1:0]        useB,
  output logic [LANES*LANE_W-1:0] outWord
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] bufLane;
    logic [LANE_W-1:0] midLane;
    logic [LANE_W-1:0] outLane;
    logic [LANE_W-1:0] pickLane;

    always_comb begin
      if (useA[l]) begin
        pickLane = wrData[l*LANE_W +: LANE_W];
      end else if (useB[l]) begin
        pickLane = bufLane;
      end else begin
        pickLane = mem[addr];
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.capData) begin
        bufLane <= wrData[l*LANE_W +: LANE_W];
      end
      if (strobe.commitEn && commitBe[l]) begin
        mem[commitAddr] <= bufLane;
      end
      if (strobe.loadMid) begin
        midLane <= pickLane;
      end
      if (strobe.loadOut) begin
        outLane <= midLane;
      end
    end

    assign outWord[l*LANE_W +: LANE_W] = outLane;
  end

endmodule

// File: rtl/lateWriteSram.sv
module lateWriteSram
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selN,
  input  logic              wrN,
  input  logic [LANES-1:0]  byteWrN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sleep,
  input  logic              oeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdOn
);

  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] commitAddr;
  logic [LANES-1:0]  commitBe;
  logic [LANES-1:0]  useA;
  logic [LANES-1:0]  useB;
  logic              driveOn;
  logic              sleepOn;
  logic [DATA_W-1:0] outWord;

  lwsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .wrN(wrN),
    .byteWrN(byteWrN), .sleep(sleep), .strobe(strobe),
    .commitAddr(commitAddr), .commitBe(commitBe), .useA(useA), .useB(useB),
    .driveOn(driveOn), .sleepOn(sleepOn)
  );

  lwsram_data #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) i_data (
    .clk(clk), .strobe(strobe), .addr(addr), .wrData(wrData),
    .commitAddr(commitAddr), .commitBe(commitBe), .useA(useA), .useB(useB),
    .outWord(outWord)
  );

  assign rdOn   = driveOn && !sleepOn && !oeN;
  assign rdData = rdOn ? outWord : '0;

endmodule

// File: rtl/lwsram_checker.sv
module lwsram_checker (
  input logic clk,
  input logic rstN,
  input logic selN,
  input logic wrN,
  input logic sleep,
  input logic oeN,
  input logic rdOn
);

  assert_drive_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdOn |-> $past((!selN && wrN && !sleep), 2));

  assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past((!selN && !wrN), 2) |-> !rdOn);

  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(selN, 2) |-> !rdOn);

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(sleep) |-> !rdOn);

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !rdOn);

endmodule

bind lateWriteSram lwsram_checker i_lwsramChecker (
  .clk(clk), .rstN(rstN), .selN(selN), .wrN(wrN),
  .sleep(sleep), .oeN(oeN), .rdOn(rdOn)
);

// File: tb/test_lateWriteSram.sv
module test_lateWriteSram;

  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int DW = LW * NL;
  localparam logic [DW-1:0] JUNK = 36'h9_A5A5_A5A5;
  localparam logic [DW-1:0] ONES = 36'hF_FFFF_FFFF;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          selN = 1'b1;
  logic          wrN = 1'b1;
  logic [NL-1:0] byteWrN = '1;
  logic [DW-1:0] wrData = '0;
  logic          sleep = 1'b0;
  logic          oeN = 1'b0;
  logic [DW-1:0] rdData;
  logic          rdOn;

  int nChk = 0;
  int nBad = 0;

  logic [DW-1:0] refMem [1 << AW];
  logic          pendV = 1'b0;
  logic [AW-1:0] pendA = '0;
  logic [NL-1:0] pendBe = '1;
  logic [DW-1:0] pendD = '0;
  logic [DW-1:0] readExp = '0;

  lateWriteSram i_lateWriteSram (
    .clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .wrN(wrN),
    .byteWrN(byteWrN), .wrData(wrData), .sleep(sleep), .oeN(oeN),
    .rdData(rdData), .rdOn(rdOn)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: inputs set at a falling edge, ends at the next falling edge
  task automatic step(input bit s, input bit w, input logic [NL-1:0] beN,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input bit slp);
    selN = !s; wrN = !w; byteWrN = beN; addr = a; sleep = slp;
    if (pendV) begin
      wrData = pendD;
      for (int l = 0; l < NL; l++)
        if (!pendBe[l]) refMem[pendA][l*LW +: LW] = pendD[l*LW +: LW];
    end else begin
      wrData = JUNK;
    end
    pendV = s && w && !slp; pendA = a; pendBe = beN; pendD = d;
    if (s && !w && !slp) readExp = refMem[a];
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 4'hF, '0, '0, 0);
  endtask

  task automatic tReset();
    chk("R11 rdOn", {35'd0, rdOn}, 36'd0);
    chk("R11 rdData", rdData, '0);
  endtask

  task automatic tBypassA();
    logic [DW-1:0] e;
    step(1, 1, 4'h0, 6'd3, 36'h1_2345_6789, 0);
    step(1, 0, 4'hF, 6'd3, '0, 0);
    e = readExp;
    chk("R1 no drive one edge after read", {35'd0, rdOn}, 36'd0);
    idle();
    chk("R1 drive after second edge", {35'd0, rdOn}, 36'd1);
    chk("R3 same-edge data", rdData, e);
    chk("R3 literal", rdData, 36'h1_2345_6789);
  endtask

  task automatic tBypassB();
    step(1, 1, 4'h0, 6'd9, 36'h0_ABCD_EF01, 0);
    idle();
    step(1, 0, 4'hF, 6'd9, '0, 0);
    idle();
    chk("R4 buffered data", rdData, 36'h0_ABCD_EF01);
    chk("R2 data taken one edge late", rdData, readExp);
  endtask

  task automatic tPartial();
    step(1, 1, 4'h0, 6'd12, 36'h5_5555_5555, 0);
    step(1, 1, 4'h0, 6'd13, 36'h1_1111_1111, 0);
    step(1, 1, 4'h0, 6'd14, 36'h2_2222_2222, 0);
    step(1, 1, 4'b1101, 6'd12, 36'h0_0003_FE00, 0);
    idle();
    step(1, 0, 4'hF, 6'd12, '0, 0);
    idle();
    chk("R5 lane1 merge", rdData, readExp);
    step(1, 1, 4'b0111, 6'd12, 36'hA_BC00_0000, 0);
    step(1, 0, 4'hF, 6'd12, '0, 0);
    idle();
    chk("R5 lane3 merge from pending stage", rdData, readExp);
  endtask

  task automatic tPriority();
    step(1, 1, 4'h0, 6'd20, 36'h3_3333_3333, 0);
    step(1, 1, 4'b1110, 6'd20, 36'h0_0000_01AB, 0);
    step(1, 0, 4'hF, 6'd20, '0, 0);
    idle();
    chk("R6 newer lane wins", rdData, readExp);
    chk("R6 literal", rdData, 36'h3_3333_33AB & 36'hF_FFFF_FFFF | 36'h0_0000_0000);
  endtask

  task automatic tLanes();
    step(1, 1, 4'h0, 6'd40, '0, 0);
    step(1, 1, 4'b1011, 6'd40, ONES, 0);
    idle();
    step(1, 0, 4'hF, 6'd40, '0, 0);
    idle();
    chk("R7 lane2 is bits 26:18", rdData, 36'h0_07FC_0000);
    step(1, 0, 4'h0, 6'd40, ONES, 0);
    idle();
    chk("R7 wrN high means read", rdData, 36'h0_07FC_0000);
    step(1, 0, 4'hF, 6'd40, '0, 0);
    idle();
    chk("R7 no write without global enable", rdData, 36'h0_07FC_0000);
  endtask

  task automatic tStream();
    logic [DW-1:0] e0, e1, e2;
    step(1, 1, 4'h0, 6'd50, 36'h0_5050_5050, 0);
    step(1, 1, 4'h0, 6'd51, 36'h0_5151_5151, 0);
    step(1, 1, 4'h0, 6'd52, 36'h0_5252_5252, 0);
    step(1, 0, 4'hF, 6'd50, '0, 0); e0 = readExp;
    step(1, 0, 4'hF, 6'd51, '0, 0); e1 = readExp;
    chk("R1 stream word 0", rdData, e0);
    step(1, 0, 4'hF, 6'd52, '0, 0); e2 = readExp;
    chk("R1 stream word 1", rdData, e1);
    idle();
    chk("R1 stream word 2", rdData, e2);
    idle();
    chk("R8 drive off after deselect", {35'd0, rdOn}, 36'd0);
  endtask

  task automatic tDeselect();
    step(0, 1, 4'h0, 6'd50, ONES, 0);
    idle();
    step(1, 0, 4'hF, 6'd50, '0, 0);
    idle();
    chk("R8 deselected write ignored", rdData, 36'h0_5050_5050);
  endtask

  task automatic tSleep();
    step(1, 1, 4'h0, 6'd55, 36'h7_0707_0707, 0);
    step(1, 0, 4'hF, 6'd55, '0, 1);
    chk("R9 drive off in sleep", {35'd0, rdOn}, 36'd0);
    chk("R9 data zero in sleep", rdData, '0);
    step(1, 1, 4'h0, 6'd51, ONES, 1);
    chk("R9 still off", {35'd0, rdOn}, 36'd0);
    idle();
    step(1, 0, 4'hF, 6'd51, '0, 0);
    idle();
    chk("R9 write in sleep ignored", rdData, 36'h0_5151_5151);
    step(1, 0, 4'hF, 6'd55, '0, 0);
    idle();
    chk("R9 pending write kept", rdData, 36'h7_0707_0707);
  endtask

  task automatic tOutEnable();
    step(1, 0, 4'hF, 6'd52, '0, 0);
    idle();
    chk("R10 drive before oe", {35'd0, rdOn}, 36'd1);
    oeN = 1'b1;
    #2;
    chk("R10 oe off rdOn", {35'd0, rdOn}, 36'd0);
    chk("R10 oe off data", rdData, '0);
    oeN = 1'b0;
    #2;
    chk("R10 oe back on", rdData, 36'h0_5252_5252);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBypassA();
    tBypassB();
    tPartial();
    tPriority();
    tLanes();
    tStream();
    tDeselect();
    tSleep();
    tOutEnable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule